// File: doc/BRIEF.md
# Bi-Endian Load/Store Byte-Lane Aligner

This block sits between a 32-bit data-cache port and the register file. On the load side it picks the addressed byte, halfword or word out of a cache word. It right-justifies that value and fills the upper bits with copies of the sign bit or with zeros. On the store side it places register data into the lanes of the cache write word and produces a byte-enable mask. Both sides share one byte offset, one access size and one endian-mode input, and both results are produced every cycle.

The endian mode does not add a swap stage to the data path. It only changes how the select values for the existing lane multiplexers are derived. In little-endian mode, address offset k lives in lane k (bits 8k+7:8k). In big-endian mode it lives in lane 3-k. Store data is copied across all lanes, so the byte-enable mask alone decides which bytes are written. A registered output stage, present by default, gives one cycle of latency.

Top module: `lane_aligner`

## Requirements
- R1: A byte load (size code 00) returns, in result bits 7:0, the cache lane equal to the offset in little-endian mode and the lane equal to 3 minus the offset in big-endian mode.
- R2: A halfword load (size code 01) reads the lane pair holding the addressed halfword: pair 0 is lanes 1:0 and pair 1 is lanes 3:2. In little-endian mode offset 0 selects pair 0 and offset 2 selects pair 1, and the two are swapped in big-endian mode. The upper lane of the pair always becomes result bits 15:8.
- R3: A word load (size code 10, offset 0) returns the cache word unchanged in both endian modes.
- R4: A signed byte load copies bit 7 of the result into bits 31:8, and a signed halfword load copies bit 15 into bits 31:16. Unsigned loads put zeros in those bits.
- R5: A byte store sets exactly one byte enable, at the lane chosen under the R1 mapping, and drives the register's low byte onto all four lanes.
- R6: A halfword store sets byte enables 0011 or 1100 for the pair chosen under the R2 mapping, and drives the register's low halfword onto both halves.
- R7: A word store sets byte enables 1111 and drives the register value unchanged.
- R8: Certain requests raise the misalign output, force the byte enables to 0000 and force the load result to zero. These are a word access with a non-zero offset, a halfword access with an odd offset, and size code 11.
- R9: With the output register present, every output reflects the inputs sampled at the previous rising clock edge, and all outputs are zero while reset (active low) is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | 1 selects big-endian lane mapping |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| ld_signed | input | 1 | 1 sign-extends loads, 0 zero-extends |
| byte_off | input | 2 | Byte offset of the access within the word |
| cache_word | input | 32 | Word read from the data cache |
| store_src | input | 32 | Register value to be stored |
| load_value | output | 32 | Aligned and extended load result |
| store_data | output | 32 | Lane-replicated store write data |
| store_be | output | 4 | Store byte-enable mask, bit i for lane i |
| misalign | output | 1 | Request violates alignment or uses size 11 |

## Verification
The hardest case to reach is a sign fill that comes from a lane other than lane 0. Examples are a big-endian signed byte load at offset 1, where the sign sits in bit 23 of the cache word, or a halfword whose sign sits in lane 1 rather than lane 3. A random word seldom places a set top bit in exactly the selected lane while the other lanes hold distinguishable values. The stimulus therefore uses patterns with a distinct value in each lane, with alternating top bits and their complements. It then sweeps every offset, both modes and both extension flags for each size, so that each lane serves as the sign source with its top bit both set and clear.

// File: rtl/la_pkg.sv
`timescale 1ns/1ps
package la_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // Alignment rule: halfwords on even offsets, words on offset zero only.
  function automatic logic bad_align(acc_size_e sz, logic off_nonzero, logic off_odd);
    case (sz)
      SZ_BYTE: bad_align = 1'b0;
      SZ_HALF: bad_align = off_odd;
      SZ_WORD: bad_align = off_nonzero;
      default: bad_align = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/la_sel_gen.sv
`timescale 1ns/1ps
module la_sel_gen
  import la_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0]      byte_off,
  input  acc_size_e             size,
  input  logic                  big_endian,
  output logic [OFF_W-1:0]      byte_lane,
  output logic [OFF_W-2:0]      pair_idx,
  output logic [(1<<OFF_W)-1:0] be,
  output logic                  misal
);
  localparam int LANES = 1 << OFF_W;
  localparam int PW    = OFF_W - 1;

  // Endian mode only flips the select values; the data path is untouched.
  assign byte_lane = byte_off ^ {OFF_W{big_endian}};
  assign pair_idx  = byte_off[OFF_W-1:1] ^ {PW{big_endian}};
  assign misal     = bad_align(size, |byte_off, byte_off[0]);

  always_comb begin
    be = '0;
    if (!misal) begin
      case (size)
        SZ_BYTE: be = LANES'(1) << byte_lane;
        SZ_HALF: be = LANES'(3) << {pair_idx, 1'b0};
        SZ_WORD: be = '1;
        default: be = '0;
      endcase
    end
  end
endmodule

// File: rtl/la_load_mux.sv
`timescale 1ns/1ps
module la_load_mux
  import la_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           cache_word,
  input  logic [$clog2(DATA_W/8)-1:0] byte_lane,
  input  logic [$clog2(DATA_W/8)-2:0] pair_idx,
  input  acc_size_e                   size,
  input  logic                        ld_signed,
  input  logic                        misal,
  output logic [DATA_W-1:0]           result
);
  localparam int LANES = DATA_W / 8;

  logic [7:0] lane [LANES];
  logic [7:0] b_pick, h_lo, h_hi, fill8;
  logic       sign_src;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = cache_word[8*g +: 8];
    end
  endgenerate

  assign b_pick   = lane[byte_lane];
  assign h_lo     = lane[{pair_idx, 1'b0}];
  assign h_hi     = lane[{pair_idx, 1'b1}];
  assign sign_src = (size == SZ_BYTE) ? b_pick[7] : h_hi[7];
  assign fill8    = {8{ld_signed & sign_src}};

  // Result byte 0: any lane. Byte 1: own lane or upper lane of a pair.
  // Higher bytes: own lane for a word, otherwise fill.
  generate
    for (g = 0; g < LANES; g++) begin : g_res
      logic [7:0] rb;
      if (g == 0) begin : g_b0
        always_comb begin
          case (size)
            SZ_BYTE: rb = b_pick;
            SZ_HALF: rb = h_lo;
            default: rb = lane[0];
          endcase
        end
      end else if (g == 1) begin : g_b1
        always_comb begin
          case (size)
            SZ_HALF: rb = h_hi;
            SZ_WORD: rb = lane[1];
            default: rb = fill8;
          endcase
        end
      end else begin : g_bn
        assign rb = (size == SZ_WORD) ? lane[g] : fill8;
      end
      assign result[8*g +: 8] = misal ? 8'h00 : rb;
    end
  endgenerate
endmodule

// File: rtl/la_store_steer.sv
`timescale 1ns/1ps
module la_store_steer
  import la_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] store_src,
  input  acc_size_e         size,
  output logic [DATA_W-1:0] wdata
);
  localparam int LANES = DATA_W / 8;

  // Replicate so that the byte enables alone pick the written lanes.
  always_comb begin
    case (size)
      SZ_BYTE: wdata = {LANES{store_src[7:0]}};
      SZ_HALF: wdata = {(LANES/2){store_src[15:0]}};
      default: wdata = store_src;
    endcase
  end
endmodule

// File: rtl/lane_aligner.sv
`timescale 1ns/1ps
module lane_aligner
  import la_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        big_endian,
  input  logic [1:0]                  acc_size,
  input  logic                        ld_signed,
  input  logic [$clog2(DATA_W/8)-1:0] byte_off,
  input  logic [DATA_W-1:0]           cache_word,
  input  logic [DATA_W-1:0]           store_src,
  output logic [DATA_W-1:0]           load_value,
  output logic [DATA_W-1:0]           store_data,
  output logic [DATA_W/8-1:0]         store_be,
  output logic                        misalign
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  acc_size_e          size_e;
  logic [OFF_W-1:0]   byte_lane;
  logic [OFF_W-2:0]   pair_idx;
  // Combinational stage outputs, named for the bound checker.
  logic [DATA_W-1:0]  load_value_c;
  logic [DATA_W-1:0]  store_data_c;
  logic [LANES-1:0]   store_be_c;
  logic               misalign_c;

  assign size_e = acc_size_e'(acc_size);

  la_sel_gen #(.OFF_W(OFF_W)) u_sel (
    .byte_off  (byte_off),
    .size      (size_e),
    .big_endian(big_endian),
    .byte_lane (byte_lane),
    .pair_idx  (pair_idx),
    .be        (store_be_c),
    .misal     (misalign_c)
  );

  la_load_mux #(.DATA_W(DATA_W)) u_ld (
    .cache_word(cache_word),
    .byte_lane (byte_lane),
    .pair_idx  (pair_idx),
    .size      (size_e),
    .ld_signed (ld_signed),
    .misal     (misalign_c),
    .result    (load_value_c)
  );

  la_store_steer #(.DATA_W(DATA_W)) u_st (
    .store_src(store_src),
    .size     (size_e),
    .wdata    (store_data_c)
  );

  generate
    if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          load_value <= '0;
          store_data <= '0;
          store_be   <= '0;
          misalign   <= 1'b0;
        end else begin
          load_value <= load_value_c;
          store_data <= store_data_c;
          store_be   <= store_be_c;
          misalign   <= misalign_c;
        end
      end
    end else begin : g_comb
      assign load_value = load_value_c;
      assign store_data = store_data_c;
      assign store_be   = store_be_c;
      assign misalign   = misalign_c;
    end
  endgenerate
endmodule

// File: rtl/la_aligner_chk.sv
`timescale 1ns/1ps
module la_aligner_chk #(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [1:0]                  acc_size,
  input logic                        ld_signed,
  input logic [$clog2(DATA_W/8)-1:0] byte_off,
  input logic [DATA_W-1:0]           cache_word,
  input logic [DATA_W-1:0]           load_c,
  input logic [DATA_W/8-1:0]         be_c,
  input logic                        misal_c,
  input logic [DATA_W-1:0]           load_q,
  input logic [DATA_W/8-1:0]         be_q
);
  p_word_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'b10 && byte_off == '0) |-> load_c == cache_word);

  p_sign_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'b00 && ld_signed) |-> load_c[DATA_W-1:8] == {(DATA_W-8){load_c[7]}});

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'b01 && !ld_signed) |-> load_c[DATA_W-1:16] == '0);

  p_byte_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'b00) |-> $countones(be_c) == 1);

  p_half_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'b01 && !misal_c) |-> (be_c == 4'b0011 || be_c == 4'b1100));

  p_misal_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misal_c |-> (be_c == '0 && load_c == '0));

  generate
    if (OUT_REG) begin : g_reg_chk
      p_reg_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (load_q == $past(load_c) && be_q == $past(be_c)));
    end
  endgenerate
endmodule

bind lane_aligner la_aligner_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_size  (acc_size),
  .ld_signed (ld_signed),
  .byte_off  (byte_off),
  .cache_word(cache_word),
  .load_c    (load_value_c),
  .be_c      (store_be_c),
  .misal_c   (misalign_c),
  .load_q    (load_value),
  .be_q      (store_be)
);

// File: tb/lane_aligner_tb.sv
`timescale 1ns/1ps
module lane_aligner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic [1:0]  acc_size = 2'b00;
  logic        ld_signed = 1'b0;
  logic [1:0]  byte_off = 2'b00;
  logic [31:0] cache_word = '0;
  logic [31:0] store_src = '0;
  logic [31:0] load_value, store_data;
  logic [3:0]  store_be;
  logic        misalign;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .acc_size(acc_size),
    .ld_signed(ld_signed), .byte_off(byte_off), .cache_word(cache_word),
    .store_src(store_src), .load_value(load_value), .store_data(store_data),
    .store_be(store_be), .misalign(misalign)
  );

  logic [31:0] pats [4] = '{32'h8A7B_9C6D, 32'h7F80_01FE, 32'h1122_8344, 32'hF00D_4B1E};

  // Memory view: the byte at address a, under the chosen mode.
  function automatic logic [7:0] mem_at(logic [31:0] w, int a, bit big);
    int ln = big ? (3 - a) : a;
    return w[8*ln +: 8];
  endfunction

  function automatic bit exp_bad(int sz, int off);
    if (sz == 3) return 1'b1;
    if (sz == 2) return off != 0;
    if (sz == 1) return (off % 2) != 0;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_load(logic [31:0] w, int off, int sz, bit sgn, bit big);
    logic [31:0] v;
    if (exp_bad(sz, off)) return 32'h0;
    if (sz == 0) begin
      v = {24'h0, mem_at(w, off, big)};
      if (sgn && v[7]) v[31:8] = 24'hFFFFFF;
    end else if (sz == 1) begin
      if (big) v = {16'h0, mem_at(w, off, big), mem_at(w, off + 1, big)};
      else     v = {16'h0, mem_at(w, off + 1, big), mem_at(w, off, big)};
      if (sgn && v[15]) v[31:16] = 16'hFFFF;
    end else begin
      if (big) v = {mem_at(w,0,big), mem_at(w,1,big), mem_at(w,2,big), mem_at(w,3,big)};
      else     v = {mem_at(w,3,big), mem_at(w,2,big), mem_at(w,1,big), mem_at(w,0,big)};
    end
    return v;
  endfunction

  // Enables come from the set of addresses a store touches.
  function automatic logic [3:0] exp_be(int off, int sz, bit big);
    logic [3:0] m = 4'b0000;
    int n;
    if (exp_bad(sz, off)) return 4'b0000;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int a = off; a < off + n; a++) m[big ? (3 - a) : a] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_wdata(logic [31:0] d, int sz);
    if (sz == 0) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (sz == 1) return {d[15:0], d[15:0]};
    return d;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive away from the rising edge, then sample just after it.
  task automatic apply(bit big, int sz, bit sgn, int off, logic [31:0] w, logic [31:0] d);
    @(negedge clk);
    big_endian = big; acc_size = 2'(sz); ld_signed = sgn;
    byte_off = 2'(off); cache_word = w; store_src = d;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "reset load", load_value, 32'h0);
    chk("R9", "reset wdata", store_data, 32'h0);
    chk("R9", "reset be", {28'h0, store_be}, 32'h0);
    chk("R9", "reset misalign", {31'h0, misalign}, 32'h0);
  endtask

  task automatic t_loads(int sz, string req);
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 4; p++)
          for (int o = 0; o < 4; o += (sz == 0 ? 1 : (sz == 1 ? 2 : 4))) begin
            apply(bit'(b), sz, bit'(s), o, pats[p], 32'h0);
            chk(req, $sformatf("load be=%0d sgn=%0d off=%0d", b, s, o),
                load_value, exp_load(pats[p], o, sz, bit'(s), bit'(b)));
            if (s == 1) chk("R4", "signed ext", load_value, exp_load(pats[p], o, sz, 1'b1, bit'(b)));
            chk(req, "no misalign", {31'h0, misalign}, 32'h0);
          end
  endtask

  task automatic t_stores(int sz, string req);
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 4; p++)
        for (int o = 0; o < 4; o += (sz == 0 ? 1 : (sz == 1 ? 2 : 4))) begin
          apply(bit'(b), sz, 1'b0, o, 32'h0, pats[p]);
          chk(req, $sformatf("store be big=%0d off=%0d", b, o), {28'h0, store_be}, {28'h0, exp_be(o, sz, bit'(b))});
          chk(req, $sformatf("store data big=%0d off=%0d", b, o), store_data, exp_wdata(pats[p], sz));
        end
  endtask

  task automatic t_misalign();
    for (int b = 0; b < 2; b++)
      for (int sz = 1; sz < 4; sz++)
        for (int o = 0; o < 4; o++) begin
          if (!exp_bad(sz, o)) continue;
          apply(bit'(b), sz, 1'b1, o, 32'hFFFF_FFFF, 32'hA5A5_A5A5);
          chk("R8", $sformatf("misalign sz=%0d off=%0d", sz, o), {31'h0, misalign}, 32'h1);
          chk("R8", "misaligned be", {28'h0, store_be}, 32'h0);
          chk("R8", "misaligned load", load_value, 32'h0);
        end
  endtask

  task automatic t_latency();
    apply(1'b0, 2, 1'b0, 0, 32'h1234_5678, 32'h0);
    @(negedge clk);
    cache_word = 32'hCAFE_F00D;
    #5;
    chk("R9", "holds before edge", load_value, 32'h1234_5678);
    @(posedge clk);
    #1;
    chk("R9", "updates after edge", load_value, 32'hCAFE_F00D);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_loads(0, "R1");
    t_loads(1, "R2");
    t_loads(2, "R3");
    t_stores(0, "R5");
    t_stores(1, "R6");
    t_stores(2, "R7");
    t_misalign();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule